// File: doc/BRIEF.md
# Two-wire bus recovery unit

This block brings a stuck two-wire serial bus back to idle when asked. A one-cycle start pulse makes it let go of both open-drain lines and wait for them to settle. It then reads the clock line. A clock held low means a slave is stretching without end, and nothing can be done about that. If the clock is free, the unit reads the data line and issues clock pulses one at a time until the slave lets go of the data line or the pulse budget is spent.

Each clock pulse uses the same timing as the byte-level bit engine of the bus master. The low phase lasts a fixed hold time. After the line is released, the unit waits for the clock to read high, allowing for clock stretching with a bounded wait. The high level is then held for the same hold time. Software or a higher-level sequencer starts the unit and reads a one-cycle done pulse together with sticky ok and error flags. Sending a STOP afterwards and deciding whether to try again are left to that caller.

Top module: `i2c_unstick`

## Requirements
- R1: While reset is active, and in the first cycle after it, both line enables are inactive and done, ok and error are 0. A reset in the middle of a recovery releases the clock line.
- R2: The data-line enable is never asserted. The clock-line enable (1 = pull low) is asserted only during the low phase of a recovery pulse.
- R3: After start, the unit waits HOLD_CYC cycles with both lines released. If the clock input then reads 0, the unit finishes with error, issues no pulse, and raises done within HOLD_CYC+2 cycles of start.
- R4: If the data input reads 1 at the first check, the unit finishes with ok and issues no clock pulse.
- R5: The data input is checked before every pulse. The unit finishes with ok at the first check that reads 1, so a slave that frees the data line after k rising clock edges (1 <= k <= PULSE_MAX-1) gets exactly k pulses.
- R6: After PULSE_MAX pulses (default 9) the unit finishes with error and makes no further check and no further pulse, even when the data line came free during the last pulse.
- R7: Every pulse holds the clock enable asserted for exactly HOLD_CYC consecutive cycles.
- R8: After releasing the clock line, the unit waits until the clock input reads 1. The line then stays released for at least HOLD_CYC cycles before the next pulse.
- R9: If the clock input stays low for more than STRETCH_MAX cycles after release, the unit stops waiting and carries on. A run never takes longer than PULSE_MAX*(2*HOLD_CYC+STRETCH_MAX+3)+HOLD_CYC+4 cycles.
- R10: done is high for exactly one cycle per run. ok and error are never both 1, exactly one of them is 1 with done, and both keep their value until the next start is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin recovery, accepted when idle |
| scl_i | input | 1 | Synchronized clock-line level |
| sda_i | input | 1 | Synchronized data-line level |
| scl_pull_o | output | 1 | Clock-line open-drain enable, 1 pulls the line low |
| sda_pull_o | output | 1 | Data-line open-drain enable, 1 pulls the line low |
| done_o | output | 1 | One-cycle pulse when a recovery attempt ends |
| ok_o | output | 1 | Last attempt freed the bus, held until the next start |
| err_o | output | 1 | Last attempt failed, held until the next start |

## Verification
On every cycle, the assertions check the shape of the result handshake: done lasts one cycle, ok and error stay exclusive and stable while idle, and a success only follows a high data reading. They also check that the pulse count never exceeds its budget, that the stuck-clock decision lands in the cycle after the settle window, that no pulse is requested while one is in flight, and that a low phase is never cut short. The pulse counts for each slave release point, the boundary between release after eight edges and after nine, how long the clock stays high after a stretched release, and the bounded run time under endless stretching all depend on a modelled slave. Only the bench's scenarios show those.

// File: rtl/recov_pkg.sv
// Package: shared state encodings for the bus recovery unit.
// Assumes: imported by the pulse generator and the controller.
package recov_pkg;

    // Phases of one clock pulse on the bus.
    typedef enum logic [1:0] {
        PS_IDLE,
        PS_LOW,
        PS_RISE,
        PS_HIGH
    } pulse_st_e;

    // Steps of one recovery attempt.
    typedef enum logic [1:0] {
        CS_IDLE,
        CS_SETTLE,
        CS_CHECK,
        CS_PULSE
    } ctrl_st_e;

endpackage

// File: rtl/scl_pulse_gen.sv
// Module: scl_pulse_gen
// Generates one clock pulse per fire request. The line is pulled low for
// HOLD_CYC cycles and then released. The module waits for the line to read
// high, allowing for stretching, and gives up after STRETCH_MAX cycles. It
// then keeps the line high for HOLD_CYC cycles and pulses fin_o in the last
// of them.
// Assumes: scl_i is already synchronized; fire_i arrives only when idle.
module scl_pulse_gen
    import recov_pkg::*;
#(
    parameter int HOLD_CYC    = 8,
    parameter int STRETCH_MAX = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic scl_i,
    output logic scl_pull_o,
    output logic fin_o
);

    localparam int CNT_MAX = (HOLD_CYC > STRETCH_MAX) ? HOLD_CYC : STRETCH_MAX;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] STR_LAST  = CW'(STRETCH_MAX - 1);

    pulse_st_e      st;
    logic [CW-1:0]  cnt;

    // Phase sequencer: low hold, stretch wait, high hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= PS_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                PS_IDLE: begin
                    cnt <= '0;
                    if (fire_i) st <= PS_LOW;
                end
                PS_LOW: begin
                    if (cnt == HOLD_LAST) begin
                        st  <= PS_RISE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PS_RISE: begin
                    if (scl_i || cnt == STR_LAST) begin
                        st  <= PS_HIGH;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == HOLD_LAST) begin
                        st  <= PS_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Output decode from the phase.
    assign scl_pull_o = (st == PS_LOW);
    assign fin_o      = (st == PS_HIGH) && (cnt == HOLD_LAST);

    // R7
    low_phase_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull_o && cnt != HOLD_LAST) |=> scl_pull_o);

    // R2
    no_fire_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |-> (st == PS_IDLE));

    // R9
    stretch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_RISE) |-> (cnt <= STR_LAST));

endmodule

// File: rtl/recov_ctrl.sv
// Module: recov_ctrl
// Sequences one recovery attempt. It lets the lines settle for HOLD_CYC
// cycles and fails at once if the clock reads low. It then checks the data
// line before each pulse, for at most PULSE_MAX pulses, and reports through
// a one-cycle done with sticky ok/error flags.
// Assumes: inputs are synchronized; fin_i comes from scl_pulse_gen.
module recov_ctrl
    import recov_pkg::*;
#(
    parameter int HOLD_CYC  = 8,
    parameter int PULSE_MAX = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    input  logic fin_i,
    output logic fire_o,
    output logic done_o,
    output logic ok_o,
    output logic err_o
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int PW = $clog2(PULSE_MAX + 1);
    localparam logic [HW-1:0] SETTLE_LAST = HW'(HOLD_CYC - 1);
    localparam logic [PW-1:0] PULSE_LAST  = PW'(PULSE_MAX - 1);

    ctrl_st_e       st;
    logic [HW-1:0]  settle_cnt;
    logic [PW-1:0]  pulses;

    // Pulse request: data still held low at a check.
    assign fire_o = (st == CS_CHECK) && !sda_i;

    // Attempt sequencer and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= CS_IDLE;
            settle_cnt <= '0;
            pulses     <= '0;
            done_o     <= 1'b0;
            ok_o       <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st)
                CS_IDLE: begin
                    if (start_i) begin
                        st         <= CS_SETTLE;
                        settle_cnt <= '0;
                        pulses     <= '0;
                        ok_o       <= 1'b0;
                        err_o      <= 1'b0;
                    end
                end
                CS_SETTLE: begin
                    if (settle_cnt == SETTLE_LAST) begin
                        if (!scl_i) begin
                            st     <= CS_IDLE;
                            done_o <= 1'b1;
                            err_o  <= 1'b1;
                        end else begin
                            st <= CS_CHECK;
                        end
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                CS_CHECK: begin
                    if (sda_i) begin
                        st     <= CS_IDLE;
                        done_o <= 1'b1;
                        ok_o   <= 1'b1;
                    end else begin
                        st <= CS_PULSE;
                    end
                end
                default: begin
                    if (fin_i) begin
                        pulses <= pulses + 1'b1;
                        if (pulses == PULSE_LAST) begin
                            st     <= CS_IDLE;
                            done_o <= 1'b1;
                            err_o  <= 1'b1;
                        end else begin
                            st <= CS_CHECK;
                        end
                    end
                end
            endcase
        end
    end

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && err_o) && (done_o -> (ok_o || err_o)));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_IDLE && !start_i) |=> ($stable(ok_o) && $stable(err_o)));

    // R5
    ok_needs_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> $past(sda_i));

    // R6
    pulse_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulses <= PW'(PULSE_MAX));

    // R3
    scl_stuck_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_SETTLE && settle_cnt == SETTLE_LAST && !scl_i) |=> (err_o && done_o));

endmodule

// File: rtl/i2c_unstick.sv
// Module: i2c_unstick (top)
// Bus recovery unit: the controller decides when to pulse, and the pulse
// generator drives the clock line with stretch-aware timing. The data line
// is never driven; it stays released so the slave can free it.
// Assumes: scl_i/sda_i come through synchronizers outside this block.
module i2c_unstick #(
    parameter int HOLD_CYC    = 8,
    parameter int STRETCH_MAX = 32,
    parameter int PULSE_MAX   = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic done_o,
    output logic ok_o,
    output logic err_o
);

    logic fire;
    logic fin;

    // Attempt controller.
    recov_ctrl #(
        .HOLD_CYC  (HOLD_CYC),
        .PULSE_MAX (PULSE_MAX)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .fin_i   (fin),
        .fire_o  (fire),
        .done_o  (done_o),
        .ok_o    (ok_o),
        .err_o   (err_o)
    );

    // Clock pulse timing.
    scl_pulse_gen #(
        .HOLD_CYC    (HOLD_CYC),
        .STRETCH_MAX (STRETCH_MAX)
    ) i_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .scl_i      (scl_i),
        .scl_pull_o (scl_pull_o),
        .fin_o      (fin)
    );

    // Data line always released.
    assign sda_pull_o = 1'b0;

    // R2
    no_pull_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !scl_pull_o);

endmodule

// File: tb/test_i2c_unstick.sv
module test_i2c_unstick;

    localparam int HOLD   = 8;
    localparam int STR    = 32;
    localparam int NPULSE = 9;
    localparam int RUN_MAX = NPULSE * (2 * HOLD + STR + 3) + HOLD + 4;

    typedef struct packed {
        logic        stuck;
        logic [31:0] n_rise;
        logic [31:0] stretch;
        logic        exp_ok;
        logic [31:0] exp_pulses;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'd0,   32'd0,    1'b1, 32'd0},
        '{1'b0, 32'd1,   32'd0,    1'b1, 32'd1},
        '{1'b0, 32'd3,   32'd0,    1'b1, 32'd3},
        '{1'b0, 32'd8,   32'd0,    1'b1, 32'd8},
        '{1'b0, 32'd9,   32'd0,    1'b0, 32'd9},
        '{1'b0, 32'd999, 32'd0,    1'b0, 32'd9},
        '{1'b1, 32'd0,   32'd0,    1'b0, 32'd0},
        '{1'b0, 32'd2,   32'd10,   1'b1, 32'd2},
        '{1'b0, 32'd999, 32'd1000, 1'b0, 32'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic scl_pull, sda_pull, done, ok, err;

    int checks = 0;
    int errors = 0;
    int wd = 0;

    // slave model state
    bit stuck = 1'b0;
    int release_after = 0;
    int stretch_len = 0;
    int rises = 0;
    int str_cnt = 1000000;
    bit prev_line = 1'b1;

    always #5 clk = ~clk;

    i2c_unstick #(.HOLD_CYC(HOLD), .STRETCH_MAX(STR), .PULSE_MAX(NPULSE)) i_i2c_unstick (
        .clk(clk), .rst_n(rst_n), .start_i(start), .scl_i(scl_in), .sda_i(sda_in),
        .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .done_o(done), .ok_o(ok), .err_o(err)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_true(string req, string what, bit cond, int act, int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Update the modelled bus lines from the design's enables (called at negedge).
    task automatic drive_lines();
        bit line;
        if (scl_pull) str_cnt = 0;
        else if (str_cnt < 1000000) str_cnt++;
        line = !scl_pull && !stuck && (str_cnt > stretch_len);
        if (line && !prev_line) rises++;
        prev_line = line;
        scl_in = line;
        sda_in = !sda_pull && (rises >= release_after);
    endtask

    function automatic string req_of(int i);
        case (i)
            0: return "R4";
            1, 2, 3: return "R5";
            4, 5: return "R6";
            6: return "R3";
            7: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic run_case(int idx, bit st_k, int n, int s, bit exp_ok, int exp_p);
        int cyc = 0, pulses = 0, lowlen = 0, lowmin = 99999, lowmax = 0;
        int highlen = 0, highmin = 99999;
        bit prev_pull = 1'b0, sda_seen = 1'b0;
        bit r_ok, r_err;
        string rq = req_of(idx);
        @(negedge clk);
        stuck = st_k; release_after = n; stretch_len = s;
        rises = 0; str_cnt = 1000000; prev_line = !st_k;
        drive_lines();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drive_lines();
        while (!done && cyc < RUN_MAX + 20) begin
            if (sda_pull) sda_seen = 1'b1;
            if (scl_pull) begin
                if (!prev_pull) begin
                    if (pulses > 0 && highlen < highmin) highmin = highlen;
                    pulses++;
                end
                lowlen++;
                highlen = 0;
            end else begin
                if (lowlen != 0) begin
                    if (lowlen < lowmin) lowmin = lowlen;
                    if (lowlen > lowmax) lowmax = lowlen;
                end
                lowlen = 0;
                if (scl_in) highlen++;
            end
            prev_pull = scl_pull;
            cyc++;
            @(negedge clk);
            drive_lines();
        end
        check_eq(rq, $sformatf("vec%0d done seen", idx), done, 1);
        check_eq(rq, $sformatf("vec%0d ok", idx), ok, exp_ok);
        check_eq(rq, $sformatf("vec%0d err", idx), err, !exp_ok);
        check_eq(rq, $sformatf("vec%0d pulses", idx), pulses, exp_p);
        check_eq("R2", $sformatf("vec%0d data enable", idx), sda_seen, 0);
        if (pulses > 0) begin
            check_eq("R7", $sformatf("vec%0d shortest low", idx), lowmin, HOLD);
            check_eq("R7", $sformatf("vec%0d longest low", idx), lowmax, HOLD);
        end
        if (pulses > 1 && s < STR)
            check_true("R8", $sformatf("vec%0d high before next pull", idx),
                       highmin >= HOLD, highmin, HOLD);
        if (st_k)
            check_true("R3", "stuck clock decision time", cyc <= HOLD + 2, cyc, HOLD + 2);
        check_true("R9", $sformatf("vec%0d run length", idx), cyc <= RUN_MAX, cyc, RUN_MAX);
        r_ok = ok; r_err = err;
        @(negedge clk);
        drive_lines();
        check_eq("R10", $sformatf("vec%0d done width", idx), done, 0);
        check_eq("R10", $sformatf("vec%0d ok held", idx), ok, r_ok);
        check_eq("R10", $sformatf("vec%0d err held", idx), err, r_err);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual %0d expected below %0d", wd, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state, R1
        repeat (3) @(negedge clk);
        check_eq("R1", "reset clock enable", scl_pull, 0);
        check_eq("R1", "reset data enable", sda_pull, 0);
        check_eq("R1", "reset done/ok/err", {done, ok, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "after reset flags", {done, ok, err, scl_pull}, 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            run_case(i, VECS[i].stuck, int'(VECS[i].n_rise), int'(VECS[i].stretch),
                     VECS[i].exp_ok, int'(VECS[i].exp_pulses));
            repeat (1100) begin
                @(negedge clk);
                drive_lines();
            end
        end

        // R10: a new start clears the previous error flag
        check_eq("R10", "err left from last run", err, 1);
        stuck = 1'b0; release_after = 0; stretch_len = 0; rises = 0;
        @(negedge clk);
        drive_lines();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drive_lines();
        check_eq("R10", "flags cleared by start", {ok, err, done}, 0);
        repeat (HOLD + 4) begin
            @(negedge clk);
            drive_lines();
        end
        check_eq("R4", "free bus after clear", {ok, err}, 2'b10);

        // R1: reset in the middle of a recovery releases the clock line
        release_after = 999; rises = 0;
        @(negedge clk);
        drive_lines();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (HOLD + 4) begin
            @(negedge clk);
            drive_lines();
        end
        check_eq("R2", "pulse in progress before reset", scl_pull, 1);
        rst_n = 1'b0;
        @(negedge clk);
        drive_lines();
        check_eq("R1", "clock released by reset", scl_pull, 0);
        check_eq("R1", "flags after mid-run reset", {done, ok, err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule